// File: doc/BRIEF.md
# Error Record Transfer Engine

This block moves a single error record between an exchange buffer and one slot of a record store. It reaches each memory through a byte-wide port with combinational read data. When a write is started, it fetches the length and identifier fields from the record held in the exchange buffer and validates them. It then asks an external slot manager for a slot and copies the record into that slot one byte per cycle. Every byte of the slot past the record's end is filled with 0xFF.

When a read is started, the engine resolves which record is meant. It asks the slot manager either to find a given identifier or to report the first stored one. It then checks the length field stored in the chosen slot and copies that many bytes into the exchange buffer, starting at the programmed offset.

Each operation ends with a one-cycle done pulse that carries a status code. The identifier that was finally used is held on an output until the next start. Slot selection and map upkeep belong to the slot manager. The engine talks to it through a one-cycle request that is answered by a one-cycle acknowledge.

Top module: `err_rec_mover`

## Requirements
- R1: For both operations, a record offset greater than XLEN-128 ends the operation with status 3 and no memory write. On a read, this check comes after identifier resolution. The exchange buffer holds XLEN bytes.
- R2: The record length is a little-endian 32-bit field at bytes 20..23 of the record. A length below 128 gives status 3. So does an offset plus length greater than XLEN. A write takes the field from the exchange buffer at offset+20. A read takes it from byte 20 of the slot.
- R3: A write takes the identifier from the little-endian 64-bit field at bytes 96..103 of the record. If that field is all zeros or all ones, the write ends with status 3 and issues no manager request.
- R4: A successful write copies the record's length in bytes from exchange byte offset+j into slot byte j. It fills the remaining slot bytes up to XLEN-1 with 0xFF, writes one byte per cycle, and ends with status 0. A write that hits an existing identifier reuses that identifier's slot.
- R5: The engine sends each manager request as a single-cycle `mgr_req` with `mgr_kind` and `mgr_id`. The kinds are 0 to place a write, 1 to find for a read, and 2 to report the first stored identifier. A place request that is refused ends with status 1 and leaves the store untouched.
- R6: A read on an empty store ends with status 4 on the cycle after start. It issues no request and makes no other check.
- R7: A read whose identifier is all zeros first replaces it with the first stored identifier, reported on `id_out`. A read whose identifier is all ones ends with status 3.
- R8: A read whose identifier is not found ends with status 5. In that case `id_out` shows the first stored identifier.
- R9: A successful read copies the slot's length in bytes into exchange bytes offset..offset+length-1. It leaves every other exchange byte and the whole store unchanged, and ends with status 0.
- R10: `done` is high for exactly one cycle per operation. `status` holds its value while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op_write | input | 1 | 1 = write to store, 0 = read from store |
| rec_offset | input | XAW | Record offset inside the exchange buffer |
| rec_id | input | 64 | Identifier to read |
| store_empty | input | 1 | Store holds no records |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 no space, 3 failed, 4 empty, 5 not found |
| id_out | output | 64 | Identifier used by the last operation |
| mgr_req | output | 1 | Slot manager request pulse |
| mgr_kind | output | 2 | Request kind (0 place, 1 find, 2 first) |
| mgr_id | output | 64 | Identifier for the request |
| mgr_ack | input | 1 | Manager response pulse |
| mgr_ok | input | 1 | Slot granted or found |
| mgr_slot | input | SW | Slot index granted or found |
| mgr_first_id | input | 64 | First stored identifier, all ones if none |
| xb_addr | output | XAW | Exchange buffer byte address |
| xb_rdata | input | 8 | Exchange buffer read data (combinational) |
| xb_wdata | output | 8 | Exchange buffer write data |
| xb_we | output | 1 | Exchange buffer write enable |
| st_addr | output | SAW | Store byte address {slot, byte} |
| st_rdata | input | 8 | Store read data (combinational) |
| st_wdata | output | 8 | Store write data |
| st_we | output | 1 | Store write enable |

## Verification
The assertions rely on the slot manager answering each request with exactly one `mgr_ack` one cycle later. They also rely on `store_empty` staying stable while an operation runs. The bench's manager model keeps both properties: it acknowledges on the edge after it sees a request and changes its map only inside that answer. The bench raises `start` only while `busy` is low. It changes memory contents and the map only between operations, so every status and byte image the engine produces can be predicted from the state before the start.

// File: rtl/err_rec_mover.sv
module err_rec_mover #(
  parameter int XLEN   = 256,
  parameter int SLOTS  = 4,
  parameter int MINREC = 128,
  parameter int LENPOS = 20,
  parameter int IDPOS  = 96,
  localparam int XAW   = $clog2(XLEN),
  localparam int SW    = $clog2(SLOTS),
  localparam int SAW   = XAW + SW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           op_write,
  input  logic [XAW-1:0] rec_offset,
  input  logic [63:0]    rec_id,
  input  logic           store_empty,
  output logic           busy,
  output logic           done,
  output logic [2:0]     status,
  output logic [63:0]    id_out,
  output logic           mgr_req,
  output logic [1:0]     mgr_kind,
  output logic [63:0]    mgr_id,
  input  logic           mgr_ack,
  input  logic           mgr_ok,
  input  logic [SW-1:0]  mgr_slot,
  input  logic [63:0]    mgr_first_id,
  output logic [XAW-1:0] xb_addr,
  input  logic [7:0]     xb_rdata,
  output logic [7:0]     xb_wdata,
  output logic           xb_we,
  output logic [SAW-1:0] st_addr,
  input  logic [7:0]     st_rdata,
  output logic [7:0]     st_wdata,
  output logic           st_we
);
  typedef enum logic [2:0] {S_IDLE, S_XHDR, S_REQ, S_WAIT, S_SHDR, S_CHK, S_COPY, S_DONE} state_t;

  localparam logic [1:0] K_PLACE = 2'd0, K_FIND = 2'd1, K_FIRST = 2'd2;
  localparam logic [2:0] ST_OK = 3'd0, ST_NOSPACE = 3'd1, ST_FAIL = 3'd3,
                         ST_EMPTY = 3'd4, ST_NOTFOUND = 3'd5;
  localparam logic [XAW:0] OFF_LIM = (XAW+1)'(XLEN - MINREC);

  state_t         st;
  logic [XAW-1:0] off, cnt;
  logic [31:0]    len;
  logic [63:0]    rid;
  logic [SW-1:0]  slot;
  logic [1:0]     kind;
  logic [2:0]     stat;
  logic           wr, nf;

  function automatic logic id_bad(input logic [63:0] x);
    return (x == 64'd0) || (&x);
  endfunction

  wire        off_bad_in = {1'b0, rec_offset} > OFF_LIM;
  wire        off_bad    = {1'b0, off} > OFF_LIM;
  wire [32:0] rec_end    = {1'b0, len} + 33'(off);
  wire        len_bad    = (len < 32'(MINREC)) || (rec_end > 33'(XLEN));
  wire        last_wr    = cnt == XAW'(XLEN - 1);
  wire        last_rd    = 32'(cnt) == len - 32'd1;
  wire [2:0]  bidx       = cnt[2:0] - 3'd4;

  assign busy     = st != S_IDLE;
  assign done     = st == S_DONE;
  assign status   = stat;
  assign id_out   = rid;
  assign mgr_req  = st == S_REQ;
  assign mgr_kind = kind;
  assign mgr_id   = rid;

  assign xb_addr  = (st == S_XHDR)
                    ? off + ((cnt < XAW'(4)) ? XAW'(LENPOS) + cnt : XAW'(IDPOS - 4) + cnt)
                    : off + cnt;
  assign xb_we    = (st == S_COPY) && !wr;
  assign xb_wdata = st_rdata;

  assign st_addr  = {slot, (st == S_SHDR) ? XAW'(LENPOS) + cnt : cnt};
  assign st_we    = (st == S_COPY) && wr;
  assign st_wdata = (32'(cnt) < len) ? xb_rdata : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; off <= '0; cnt <= '0; len <= '0; rid <= '0;
      slot <= '0; kind <= K_PLACE; stat <= ST_OK; wr <= 1'b0; nf <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          wr <= op_write; off <= rec_offset; rid <= rec_id;
          cnt <= '0; len <= '0; nf <= 1'b0;
          if (op_write) begin
            if (off_bad_in) begin stat <= ST_FAIL; st <= S_DONE; end
            else st <= S_XHDR;
          end else if (store_empty) begin
            stat <= ST_EMPTY; st <= S_DONE;
          end else if (rec_id == 64'd0) begin
            kind <= K_FIRST; st <= S_REQ;
          end else if (id_bad(rec_id) || off_bad_in) begin
            stat <= ST_FAIL; st <= S_DONE;
          end else begin
            kind <= K_FIND; st <= S_REQ;
          end
        end
        S_XHDR: begin
          if (cnt < XAW'(4)) len[{cnt[1:0], 3'b000} +: 8] <= xb_rdata;
          else               rid[{bidx, 3'b000} +: 8] <= xb_rdata;
          cnt <= cnt + 1'b1;
          if (cnt == XAW'(11)) st <= S_CHK;
        end
        S_SHDR: begin
          len[{cnt[1:0], 3'b000} +: 8] <= st_rdata;
          cnt <= cnt + 1'b1;
          if (cnt == XAW'(3)) st <= S_CHK;
        end
        S_CHK: begin
          cnt <= '0;
          if (len_bad || (wr && id_bad(rid))) begin stat <= ST_FAIL; st <= S_DONE; end
          else if (wr) begin kind <= K_PLACE; st <= S_REQ; end
          else st <= S_COPY;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (mgr_ack) begin
          case (kind)
            K_PLACE:
              if (mgr_ok) begin slot <= mgr_slot; cnt <= '0; st <= S_COPY; end
              else begin stat <= ST_NOSPACE; st <= S_DONE; end
            K_FIND:
              if (mgr_ok) begin slot <= mgr_slot; cnt <= '0; st <= S_SHDR; end
              else begin nf <= 1'b1; kind <= K_FIRST; st <= S_REQ; end
            default: begin
              rid <= mgr_first_id;
              if (nf) begin stat <= ST_NOTFOUND; st <= S_DONE; end
              else if (id_bad(mgr_first_id) || off_bad) begin stat <= ST_FAIL; st <= S_DONE; end
              else begin kind <= K_FIND; st <= S_REQ; end
            end
          endcase
        end
        S_COPY: begin
          cnt <= cnt + 1'b1;
          if (wr ? last_wr : last_rd) begin stat <= ST_OK; st <= S_DONE; end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mgr_req |=> !mgr_req);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(status));

  p_empty_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op_write && store_empty) |=> (done && status == 3'd4 && !mgr_req));

  p_wr_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_write && ({1'b0, rec_offset} > OFF_LIM)) |=> (done && status == 3'd3));

  p_one_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(xb_we && st_we));
endmodule

// File: tb/err_rec_mover_test.sv
module err_rec_mover_test;
  localparam int XLEN = 256, SLOTS = 4, XAW = 8, SW = 2, SAW = 10;
  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] ID_A = 64'h1111_2222_3333_4444, ID_B = 64'h0BAD_CAFE_0000_0001,
                          ID_C = 64'h7000_0000_0000_00C3, ID_D = 64'h0000_0000_0000_00D4,
                          ID_E = 64'h5555_0000_0000_00E5, ID_F = 64'h0F0F_0F0F_0F0F_0F0F;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n, start, op_write, store_empty, busy, done, mgr_req, mgr_ack, mgr_ok;
  logic xb_we, st_we;
  logic [XAW-1:0] rec_offset, xb_addr;
  logic [63:0] rec_id, id_out, mgr_id, mgr_first_id;
  logic [2:0] status;
  logic [1:0] mgr_kind;
  logic [SW-1:0] mgr_slot;
  logic [7:0] xb_rdata, xb_wdata, st_rdata, st_wdata;
  logic [SAW-1:0] st_addr;

  logic [7:0]  xb_mem [XLEN];
  logic [7:0]  st_mem [SLOTS*XLEN];
  logic [63:0] map [SLOTS];

  err_rec_mover uut (.*);

  assign xb_rdata = xb_mem[xb_addr];
  assign st_rdata = st_mem[st_addr];

  always @(posedge clk) begin
    if (xb_we) xb_mem[xb_addr] <= xb_wdata;
    if (st_we) st_mem[st_addr] <= st_wdata;
  end

  always_comb begin
    store_empty = 1'b1;
    for (int i = 0; i < SLOTS; i++) if (map[i] != 64'd0) store_empty = 1'b0;
  end

  always @(posedge clk) begin
    mgr_ack <= 1'b0;
    if (mgr_req) begin : mgr
      int hit, free;
      logic [63:0] first;
      hit = -1; free = -1; first = ONES;
      for (int i = SLOTS - 1; i >= 0; i--) begin
        if (map[i] == mgr_id) hit = i;
        if (map[i] == 64'd0) free = i;
        if (map[i] != 64'd0) first = map[i];
      end
      mgr_ack <= 1'b1;
      mgr_first_id <= first;
      mgr_ok <= 1'b0;
      if (mgr_kind == 2'd0) begin
        if (hit >= 0) begin mgr_ok <= 1'b1; mgr_slot <= SW'(hit); end
        else if (free >= 0) begin mgr_ok <= 1'b1; mgr_slot <= SW'(free); map[free] = mgr_id; end
      end else if (mgr_kind == 2'd1 && hit >= 0) begin
        mgr_ok <= 1'b1; mgr_slot <= SW'(hit);
      end
    end
  end

  int n_chk = 0, n_fail = 0, ndone = 0;
  bit finished = 0;

  task automatic chk(input logic ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  typedef struct packed { logic cid; logic [2:0] st; logic [63:0] id; } exp_t;
  exp_t  exp_q [$];
  string tag_q [$];
  logic  prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(1'b0, "R10 done pulse width", 64'd2, 64'd1);
      if (done) begin
        exp_t  e;
        string t;
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected done", 64'd1, 64'd0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(status == e.st, {t, " status"}, 64'(status), 64'(e.st));
          if (e.cid) chk(id_out == e.id, {t, " id_out"}, id_out, e.id);
        end
        ndone++;
      end
      prev_done = done;
    end
  end

  task automatic run(input logic w, input int o, input logic [63:0] id, input logic [2:0] es,
                     input logic cid, input logic [63:0] eid, input string r);
    int n0;
    n0 = ndone;
    exp_q.push_back({cid, es, eid});
    tag_q.push_back(r);
    @(negedge clk);
    start = 1'b1; op_write = w; rec_offset = XAW'(o); rec_id = id;
    @(negedge clk);
    start = 1'b0;
    while (ndone == n0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic mk(input int o, input logic [31:0] len, input logic [63:0] id, input logic [7:0] seed);
    for (int j = 0; j < XLEN; j++) xb_mem[j] = 8'h00;
    for (int j = 0; j < XLEN; j++) if (o + j < XLEN && j < int'(len)) xb_mem[o + j] = seed + 8'(j * 3);
    for (int k = 0; k < 4; k++) if (o + 20 + k < XLEN) xb_mem[o + 20 + k] = len[8*k +: 8];
    for (int k = 0; k < 8; k++) if (o + 96 + k < XLEN) xb_mem[o + 96 + k] = id[8*k +: 8];
  endtask

  task automatic chk_slot(input int s, input int o, input int len, input string r);
    int bad;
    logic [7:0] e;
    bad = 0;
    for (int j = 0; j < XLEN; j++) begin
      e = (j < len) ? xb_mem[o + j] : 8'hFF;
      if (st_mem[s*XLEN + j] != e) bad++;
    end
    chk(bad == 0, {r, " slot image"}, 64'(bad), 64'd0);
  endtask

  task automatic chk_xb(input int s, input int o, input int len, input string r);
    int bad;
    bad = 0;
    for (int j = 0; j < XLEN; j++) begin
      if (j >= o && j < o + len) begin
        if (xb_mem[j] != st_mem[s*XLEN + j - o]) bad++;
      end else if (xb_mem[j] != 8'h5A) bad++;
    end
    chk(bad == 0, {r, " exchange image"}, 64'(bad), 64'd0);
  endtask

  task automatic fill_xb();
    for (int j = 0; j < XLEN; j++) xb_mem[j] = 8'h5A;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd1, 64'd0);
    if (!finished) begin
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] m1;
    start = 0; op_write = 0; rec_offset = '0; rec_id = '0; rst_n = 0;
    mgr_ok = 0; mgr_slot = '0; mgr_first_id = '0;
    for (int i = 0; i < SLOTS; i++) map[i] = 64'd0;
    for (int j = 0; j < SLOTS*XLEN; j++) st_mem[j] = 8'h00;
    fill_xb();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mgr_req && !st_we && !xb_we, "R10 reset idle",
        64'({busy, done, mgr_req, st_we, xb_we}), 64'd0);
    chk(status == 3'd0, "R10 reset status", 64'(status), 64'd0);

    mk(0, 200, ID_A, 8'h01);
    run(1, 0, 64'd0, 3'd0, 1, ID_A, "R4 write A");
    chk_slot(0, 0, 200, "R4 write A");
    chk(map[0] == ID_A, "R5 place request id", map[0], ID_A);

    mk(100, 128, ID_B, 8'h40);
    run(1, 100, 64'd0, 3'd0, 1, ID_B, "R2 min length write");
    chk_slot(1, 100, 128, "R2 min length write");

    mk(0, 200, ID_C, 8'h03);
    run(1, 129, 64'd0, 3'd3, 0, 64'd0, "R1 write offset");
    mk(0, 127, ID_C, 8'h03);
    run(1, 0, 64'd0, 3'd3, 0, 64'd0, "R2 short length");
    mk(56, 201, ID_C, 8'h03);
    run(1, 56, 64'd0, 3'd3, 0, 64'd0, "R2 length past end");
    mk(56, 200, ID_C, 8'h07);
    run(1, 56, 64'd0, 3'd0, 1, ID_C, "R2 length to end");
    chk_slot(2, 56, 200, "R2 length to end");

    mk(0, 150, 64'd0, 8'h04);
    run(1, 0, 64'd0, 3'd3, 0, 64'd0, "R3 zero id");
    mk(0, 150, ONES, 8'h04);
    run(1, 0, 64'd0, 3'd3, 0, 64'd0, "R3 ones id");

    mk(8, 150, ID_A, 8'h90);
    run(1, 8, 64'd0, 3'd0, 1, ID_A, "R4 overwrite A");
    chk_slot(0, 8, 150, "R4 overwrite A pad");

    mk(0, 130, ID_D, 8'h05);
    run(1, 0, 64'd0, 3'd0, 1, ID_D, "R4 write D");
    m1 = {st_mem[3*XLEN+3], st_mem[3*XLEN+2], st_mem[3*XLEN+1], st_mem[3*XLEN]};
    mk(0, 130, ID_E, 8'h06);
    run(1, 0, 64'd0, 3'd1, 1, ID_E, "R5 no space");
    chk((map[0] != ID_E) && (map[3] == ID_D), "R5 map untouched", map[3], ID_D);
    chk({st_mem[3*XLEN+3], st_mem[3*XLEN+2], st_mem[3*XLEN+1], st_mem[3*XLEN]} == m1,
        "R5 store untouched",
        64'({st_mem[3*XLEN+3], st_mem[3*XLEN+2], st_mem[3*XLEN+1], st_mem[3*XLEN]}), m1);

    fill_xb();
    run(0, 10, ID_B, 3'd0, 1, ID_B, "R9 read B");
    chk_xb(1, 10, 128, "R9 read B");

    fill_xb();
    run(0, 0, 64'd0, 3'd0, 1, ID_A, "R7 read zero id");
    chk_xb(0, 0, 150, "R7 read zero id");

    fill_xb();
    run(0, 0, ID_F, 3'd5, 1, ID_A, "R8 not found");
    chk_xb(0, 0, 0, "R8 not found");
    run(0, 0, ONES, 3'd3, 1, ONES, "R7 ones id");
    run(0, 129, ID_B, 3'd3, 0, 64'd0, "R1 read offset");
    chk_xb(0, 0, 0, "R1 read offset");

    st_mem[2*XLEN + 20] = 8'd100;
    run(0, 0, ID_C, 3'd3, 1, ID_C, "R2 stored short");
    run(0, 128, ID_D, 3'd3, 1, ID_D, "R2 stored past end");
    chk_xb(0, 0, 0, "R2 stored reject");

    for (int i = 0; i < SLOTS; i++) map[i] = 64'd0;
    @(negedge clk);
    run(0, 200, ID_C, 3'd4, 0, 64'd0, "R6 empty store");
    run(0, 0, 64'd0, 3'd4, 0, 64'd0, "R6 empty zero id");
    chk_xb(0, 0, 0, "R6 empty store");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 every op done", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule